// File: doc/BRIEF.md
# Fractional Clock Divider Control Register with Atomic Aliases

This block holds the settings of four fractional clock divider channels in one 32-bit control word. Each channel owns one byte of the word. The byte carries a 6-bit divider value and a stop bit that gates the channel's clock. A simple bus with an address, a write strobe, write data and read data gives software access to the word.

The word can be written at four addresses. The base address replaces the whole word. The other three addresses change only selected bits: one forces the written ones high, one forces them low and one inverts them. Software can therefore start, stop or retune one channel with a single store, with no read-modify-write sequence and no race with code that owns a neighbouring channel.

The block turns the stored word into per-channel outputs, each taken from a register. Each channel has a 6-bit divider value and an `enabled` flag. The divider circuits that use these outputs sit outside the block.

Top module: `clkfrac_ctl_bank`

## Requirements
- R1: After reset the word reads 0x92929292. Every channel is stopped (`ch_enabled` = 0) and every `ch_frac` field holds 18.
- R2: A write to offset 0x0 replaces the stored word with the write data. Reserved bits still apply, as set out in R6.
- R3: A write to offset 0x4 ORs the write data into the stored word.
- R4: A write to offset 0x8 clears each stored bit whose write-data bit is 1 and leaves the other bits as they were.
- R5: A write to offset 0xC XORs the write data into the stored word.
- R6: Bit 6 of each byte (bits 6, 14, 22 and 30) is reserved. It always reads 0, and no write form can set it.
- R7: Channel n owns word bits [8n+7:8n]. The low 6 bits of that byte appear on `ch_frac[6n+5:6n]`.
- R8: `ch_enabled[n]` is the inverse of word bit 8n+7. Bit value 1 stops the channel and 0 runs it.
- R9: `bus_rdata` is the stored word for any address, taken from a register. A write accepted at clock edge k shows on `bus_rdata`, `ch_frac` and `ch_enabled` after edge k+1 and not before.
- R10: The word stays unchanged in two cases: when `bus_we` is 0, and during a write to any address other than 0x0, 0x4, 0x8 or 0xC (for example 0x2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | NUM_CH*LANE_W | Write data |
| bus_rdata | output | NUM_CH*LANE_W | Registered copy of the stored word |
| ch_frac | output | NUM_CH*FRAC_W | Divider value per channel, channel 0 in the low bits |
| ch_enabled | output | NUM_CH | Channel runs when 1 |

## Verification
A write updates the stored word at the edge where it is sampled. Every port result then follows one edge later, so it is due two rising edges after the inputs are driven. The bench drives inputs at a falling edge and drops the strobe at the next falling edge. It samples at the falling edge after the second rising edge. One directed test also samples at the intermediate falling edge to confirm that the outputs still hold the old value there. In the checker, assertions on the internal word use a single-cycle `$past`. Assertions that relate the channel outputs to `bus_rdata` hold in every cycle, because both are taken from the word at the same edge.

// File: rtl/clkfrac_ctl_pkg.sv
package clkfrac_ctl_pkg;

  // Update form selected by address bits [3:2]
  typedef enum logic [1:0] {
    ALIAS_WRITE = 2'd0,
    ALIAS_SET   = 2'd1,
    ALIAS_CLEAR = 2'd2,
    ALIAS_FLIP  = 2'd3
  } alias_op_t;

  typedef struct packed {
    logic      hit;
    alias_op_t op;
  } alias_req_t;

endpackage

// File: rtl/clkfrac_alias_decode.sv
module clkfrac_alias_decode
  import clkfrac_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output alias_req_t        req
);

  logic aligned;
  logic in_window;

  assign aligned   = (addr[1:0] == 2'b00);
  assign in_window = ((addr >> 4) == '0);

  always_comb begin
    req.hit = we && aligned && in_window;
    req.op  = alias_op_t'(addr[3:2]);
  end

endmodule

// File: rtl/clkfrac_alias_merge.sv
module clkfrac_alias_merge
  import clkfrac_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] wdata,
  input  alias_op_t         op,
  input  logic [DATA_W-1:0] keep_mask,
  output logic [DATA_W-1:0] nxt
);

  logic [DATA_W-1:0] raw;

  always_comb begin
    unique case (op)
      ALIAS_WRITE: raw = wdata;
      ALIAS_SET:   raw = cur | wdata;
      ALIAS_CLEAR: raw = cur & ~wdata;
      ALIAS_FLIP:  raw = cur ^ wdata;
      default:     raw = cur;
    endcase
    nxt = raw & keep_mask;
  end

endmodule

// File: rtl/clkfrac_chan_out.sv
module clkfrac_chan_out #(
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int RST_FRAC = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] lane,
  output logic [FRAC_W-1:0] frac_q,
  output logic              run_q
);

  localparam int GATE_BIT = LANE_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= FRAC_W'(RST_FRAC);
      run_q  <= 1'b0;
    end else begin
      frac_q <= lane[FRAC_W-1:0];
      run_q  <= ~lane[GATE_BIT];
    end
  end

endmodule

// File: rtl/clkfrac_ctl_bank.sv
module clkfrac_ctl_bank
  import clkfrac_ctl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int LANE_W   = 8,
  parameter int FRAC_W   = 6,
  parameter int ADDR_W   = 4,
  parameter int RST_FRAC = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [NUM_CH*LANE_W-1:0] bus_wdata,
  output logic [NUM_CH*LANE_W-1:0] bus_rdata,
  output logic [NUM_CH*FRAC_W-1:0] ch_frac,
  output logic [NUM_CH-1:0]        ch_enabled
);

  localparam int DATA_W = NUM_CH * LANE_W;
  localparam logic [LANE_W-1:0] GATE_LANE = LANE_W'(1) << (LANE_W - 1);
  localparam logic [LANE_W-1:0] FRAC_LANE = (LANE_W'(1) << FRAC_W) - LANE_W'(1);
  localparam logic [LANE_W-1:0] RST_LANE  = GATE_LANE | LANE_W'(RST_FRAC);
  localparam logic [LANE_W-1:0] KEEP_LANE = GATE_LANE | FRAC_LANE;

  function automatic logic [DATA_W-1:0] fill_lanes(input logic [LANE_W-1:0] b);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_CH; i++) r[i*LANE_W +: LANE_W] = b;
    return r;
  endfunction

  localparam logic [DATA_W-1:0] RST_WORD  = fill_lanes(RST_LANE);
  localparam logic [DATA_W-1:0] KEEP_MASK = fill_lanes(KEEP_LANE);

  alias_req_t        req;
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_nxt;
  logic [DATA_W-1:0] rdata_q;

  clkfrac_alias_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .we   (bus_we),
    .req  (req)
  );

  clkfrac_alias_merge #(.DATA_W(DATA_W)) u_merge (
    .cur       (word_q),
    .wdata     (bus_wdata),
    .op        (req.op),
    .keep_mask (KEEP_MASK),
    .nxt       (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)          word_q <= RST_WORD;
    else if (req.hit) word_q <= word_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= RST_WORD;
    else     rdata_q <= word_q;
  end

  assign bus_rdata = rdata_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    clkfrac_chan_out #(
      .LANE_W   (LANE_W),
      .FRAC_W   (FRAC_W),
      .RST_FRAC (RST_FRAC)
    ) u_out (
      .clk    (clk),
      .rst    (rst),
      .lane   (word_q[n*LANE_W +: LANE_W]),
      .frac_q (ch_frac[n*FRAC_W +: FRAC_W]),
      .run_q  (ch_enabled[n])
    );
  end

endmodule

// File: rtl/clkfrac_ctl_bank_chk.sv
module clkfrac_ctl_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int LANE_W = 8,
  parameter int FRAC_W = 6,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_we,
  input logic [NUM_CH*LANE_W-1:0] bus_wdata,
  input logic [NUM_CH*LANE_W-1:0] bus_rdata,
  input logic [NUM_CH*FRAC_W-1:0] ch_frac,
  input logic [NUM_CH-1:0]        ch_enabled,
  input logic [NUM_CH*LANE_W-1:0] word_q
);

  localparam int RSV_W = LANE_W - 1 - FRAC_W;

  AST_OR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(4)) |=> ((word_q | $past(bus_wdata)) == (word_q | $past(word_q) | $past(bus_wdata)))
      && ((word_q & ~$past(bus_wdata)) == ($past(word_q) & ~$past(bus_wdata)))); // R3

  AST_CLEAR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(8)) |=> ((word_q & $past(bus_wdata)) == '0)
      && ((word_q | $past(bus_wdata)) == ($past(word_q) | $past(bus_wdata)))); // R4

  AST_FLIP_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(12)) |=> ((word_q ^ $past(word_q)) & ~$past(bus_wdata)) == '0); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bus_we || bus_addr[1:0] != 2'b00) |=> $stable(word_q)); // R10

  AST_RDATA_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> bus_rdata == $past(word_q)); // R9

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
      bus_rdata[n*LANE_W+FRAC_W +: RSV_W] == '0); // R6
    AST_FRAC_LANE: assert property (@(posedge clk) disable iff (rst)
      ch_frac[n*FRAC_W +: FRAC_W] == bus_rdata[n*LANE_W +: FRAC_W]); // R7
    AST_RUN_INV: assert property (@(posedge clk) disable iff (rst)
      ch_enabled[n] == !bus_rdata[n*LANE_W + LANE_W - 1]); // R8
  end

endmodule

bind clkfrac_ctl_bank clkfrac_ctl_bank_chk #(
  .NUM_CH (NUM_CH),
  .LANE_W (LANE_W),
  .FRAC_W (FRAC_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .ch_frac    (ch_frac),
  .ch_enabled (ch_enabled),
  .word_q     (word_q)
);

// File: tb/sim_clkfrac_ctl_bank.sv
module sim_clkfrac_ctl_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [23:0] ch_frac;
  logic [3:0]  ch_enabled;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkfrac_ctl_bank u0 (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ch_frac    (ch_frac),
    .ch_enabled (ch_enabled)
  );

  // {tag, addr, wdata, expected word}
  localparam logic [71:0] VEC [NVEC] = '{
    {4'd2,  4'h0, 32'h0C0C0C0C, 32'h0C0C0C0C},  // R2
    {4'd3,  4'h4, 32'h00800000, 32'h0C8C0C0C},  // R3
    {4'd4,  4'h8, 32'h0C000000, 32'h008C0C0C},  // R4
    {4'd5,  4'hC, 32'h00008080, 32'h008C8C8C},  // R5
    {4'd6,  4'h0, 32'hFFFFFFFF, 32'hBFBFBFBF},  // R6
    {4'd4,  4'h8, 32'h3F00003F, 32'h80BFBF80},  // R4
    {4'd6,  4'hC, 32'h40404040, 32'h80BFBF80},  // R6
    {4'd3,  4'h4, 32'h00000023, 32'h80BFBFA3},  // R3
    {4'd10, 4'h2, 32'h00000000, 32'h80BFBFA3},  // R10
    {4'd5,  4'hC, 32'hFFFFFFFF, 32'h3F00001C},  // R5
    {4'd6,  4'h0, 32'h12345678, 32'h12341638}   // R6
  };

  task automatic check_word(input int tag, input logic [31:0] exp);
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL R%0d rdata: actual %h expected %h", tag, bus_rdata, exp);
    end
    for (int n = 0; n < 4; n++) begin
      checks++;
      if (ch_frac[n*6 +: 6] !== exp[n*8 +: 6]) begin  // R7
        fails++;
        $display("FAIL R7 (R%0d) ch%0d frac: actual %0d expected %0d",
                 tag, n, ch_frac[n*6 +: 6], exp[n*8 +: 6]);
      end
      checks++;
      if (ch_enabled[n] !== ~exp[n*8+7]) begin  // R8
        fails++;
        $display("FAIL R8 (R%0d) ch%0d enabled: actual %b expected %b",
                 tag, n, ch_enabled[n], ~exp[n*8+7]);
      end
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_word(1, 32'h92929292);  // R1
    checks++;
    if (ch_frac !== {4{6'd18}} || ch_enabled !== 4'b0000) begin  // R1
      fails++;
      $display("FAIL R1 reset outputs: actual %h/%b expected %h/0000",
               ch_frac, ch_enabled, {4{6'd18}});
    end

    for (int i = 0; i < NVEC; i++) begin
      bus_write(VEC[i][67:64], VEC[i][63:32]);
      check_word(int'(VEC[i][71:68]), VEC[i][31:0]);
    end

    // R9: output lag, sampled one falling edge after the write edge
    @(negedge clk);
    bus_addr = 4'h0; bus_wdata = 32'h00000005; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    checks++;
    if (bus_rdata !== 32'h12341638) begin  // R9
      fails++;
      $display("FAIL R9 early rdata: actual %h expected %h", bus_rdata, 32'h12341638);
    end
    @(negedge clk);
    check_word(9, 32'h00000005);

    // R10: strobe low with data on the bus; R9: read address has no effect
    @(negedge clk);
    bus_addr = 4'h0; bus_wdata = 32'hFFFFFFFF; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    check_word(10, 32'h00000005);
    bus_addr = 4'h8;
    repeat (2) @(negedge clk);
    check_word(9, 32'h00000005);

    // R10: address outside the four offsets
    bus_write(4'h6, 32'hFFFFFFFF);
    check_word(10, 32'h00000005);

    // R1: reset in mid-run restores the default word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_word(1, 32'h92929292);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

endmodule